// File: doc/BRIEF.md
# Frame-Synchronized Serial Transmitter

This block is the transmit half of a frame-synchronized serial port. A producer hands it 16-bit words through a valid/ready holding stage. When a frame-sync pulse is seen while the transmitter is idle, the held word is formatted and shifted out on a single serial line, one bit per bit clock. The first data bit can be held back by zero, one or two bit clocks after the frame start. One bit clock is the usual choice, because the first bit then lands right after a one-cycle sync pulse.

A two-bit format control picks how the word goes out. The plain format sends all 16 bits most significant first. The byte-reversed format sends only the low byte, least significant bit first. The two companding formats take a left-justified linear sample and send its 8-bit G.711 code: mu-law for a 14-bit sample and A-law for a 13-bit sample. The format and the delay are both captured at the frame start. If no fresh word is waiting when a frame begins, the last word sent goes out again and a sticky underrun flag rises.

Back-pressure rules for the input stream: a word is taken on any rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high exactly when the one-word holding register is empty. While `in_valid` is high and `in_ready` is low, the source keeps `in_data` stable. The holding register empties at each frame start, so `in_ready` returns one cycle after the frame begins.

Top module: `frame_serial_tx`

## Requirements
- R1: A frame starts at a rising `clk` edge where `fsync` is high and the transmitter is idle. An `fsync` pulse during the delay or shift phase of a word is ignored: it starts no new frame and takes no word from the holding register.
- R2: Let k be the frame-start edge. For `dly_sel` 00, 01 and 10, the first data bit appears on `sdout` after edge k, k+1 and k+2 respectively. Code 11 acts like 00.
- R3: With `fmt_sel` = 00, all 16 bits of the word go out MSB first, one per edge.
- R4: With `fmt_sel` = 01, only `in_data[7:0]` is sent: 8 bits, bit 0 first. The upper byte has no effect.
- R5: With `fmt_sel` = 10, `in_data[15:2]` is a 14-bit two's-complement sample. The block sends its 8-bit G.711 mu-law code MSB first. Magnitudes are clipped to 8158 and biased by 33. Positive codes have bit 7 set, and zero gives 0xFF.
- R6: With `fmt_sel` = 11, `in_data[15:3]` is a 13-bit two's-complement sample. The block sends its 8-bit G.711 A-law code MSB first, with the code's even bits inverted (XOR 0x55, bit 7 set for non-negative). Zero gives 0xD5.
- R7: `fmt_sel` and `dly_sel` are sampled at the frame start. Changing them while a word is in progress does not alter that word.
- R8: `sdout` is low whenever no data bit is being sent: during the delay, between words and after the last bit.
- R9: `in_ready` is high when the holding register is empty and falls the cycle after a word is accepted. At a frame start, the held word moves to the shifter and `in_ready` rises on the next cycle.
- R10: A frame that starts with an empty holding register resends the previous word (zero after reset), and `underrun` is set on the next cycle. The flag stays set until a word is accepted at an edge that is not a frame start. If a load and an underrun frame start share an edge, the flag is set.
- R11: During and right after reset, `sdout` is 0, `in_ready` is 1 and `underrun` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; everything changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame-sync input, sampled each rising edge |
| fmt_sel | input | 2 | Format: 00 MSB-first 16-bit, 01 LSB-first byte, 10 mu-law, 11 A-law |
| dly_sel | input | 2 | Data delay: 00/11 none, 01 one bit, 10 two bits |
| in_valid | input | 1 | Source has a word on `in_data` |
| in_ready | output | 1 | Holding register is empty and can take a word |
| in_data | input | 16 | Word to transmit |
| sdout | output | 1 | Serial data out |
| underrun | output | 1 | Sticky flag: a frame started with no fresh word |

## Verification
The hardest case to reach from the ports is a frame start that lands on the same edge as a load into an empty holding register. In that case the old word must be resent, the flag must still be set, and the new word must wait for the next frame. The stimulus reaches it by driving `fsync` and `in_valid` on the same falling edge, right after an underrun frame has emptied the register. The bench also raises `fsync` and flips the format and delay controls in the middle of a word. It then confirms at the ports that the word finished unchanged, that no second frame followed, and that no waiting word was consumed.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;

  // Serial formats chosen by fmt_sel
  typedef enum logic [1:0] {
    FMT_MSB16 = 2'b00,
    FMT_LSB8  = 2'b01,
    FMT_MULAW = 2'b10,
    FMT_ALAW  = 2'b11
  } tx_fmt_e;

  // Transmit sequencer states
  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_WAIT  = 2'b01,
    ST_SHIFT = 2'b10
  } tx_st_e;

  localparam int MU_LIN_W = 14;  // mu-law sample width
  localparam int A_LIN_W  = 13;  // A-law sample width
  localparam int CODE_W   = 8;   // companded / byte word width

endpackage

// File: rtl/frame_tx_mulaw.sv
module frame_tx_mulaw
  import frame_tx_pkg::*;
(
  input  logic [MU_LIN_W-1:0] lin,
  output logic [CODE_W-1:0]   code
);
  localparam int EXT_W = MU_LIN_W + 1;
  localparam int BIA_W = MU_LIN_W - 1;

  logic             sgn;
  logic [EXT_W-1:0] ext;
  logic [EXT_W-1:0] mag;
  logic [BIA_W-1:0] biased;
  logic [2:0]       seg;
  logic [3:0]       mant;

  assign sgn    = lin[MU_LIN_W-1];
  assign ext    = {lin[MU_LIN_W-1], lin};
  assign mag    = sgn ? (~ext + EXT_W'(1)) : ext;
  assign biased = (mag > EXT_W'(8158)) ? BIA_W'(8191) : (mag[BIA_W-1:0] + BIA_W'(33));

  // segment = position of the leading one above bit 5
  always_comb begin
    seg = 3'd0;
    for (int i = 1; i < 8; i++) begin
      if (biased[i+5]) seg = 3'(i);
    end
  end

  assign mant = 4'(biased >> ({1'b0, seg} + 4'd1));
  assign code = {1'b0, seg, mant} ^ (sgn ? 8'h7F : 8'hFF);

endmodule

// File: rtl/frame_tx_alaw.sv
module frame_tx_alaw
  import frame_tx_pkg::*;
(
  input  logic [A_LIN_W-1:0] lin,
  output logic [CODE_W-1:0]  code
);
  localparam int MAG_W = A_LIN_W - 1;

  logic             sgn;
  logic [MAG_W-1:0] mag;
  logic [2:0]       seg;
  logic [3:0]       mant;

  assign sgn = lin[A_LIN_W-1];
  // for negatives, -x-1 equals the one's complement of the low bits
  assign mag = sgn ? ~lin[MAG_W-1:0] : lin[MAG_W-1:0];

  always_comb begin
    seg = 3'd0;
    for (int i = 1; i < 8; i++) begin
      if (mag[i+4]) seg = 3'(i);
    end
  end

  assign mant = (seg < 3'd2) ? mag[4:1] : 4'(mag >> seg);
  assign code = {1'b0, seg, mant} ^ (sgn ? 8'h55 : 8'hD5);

endmodule

// File: rtl/frame_tx_fmt.sv
module frame_tx_fmt
  import frame_tx_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int LEN_W  = $clog2(WORD_W + 1)
) (
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        fmt,
  output logic [WORD_W-1:0] shift_word,  // MSB-aligned bits to send
  output logic [LEN_W-1:0]  shift_len
);
  localparam int PAD_W = WORD_W - CODE_W;

  logic [CODE_W-1:0] rev_byte;
  logic [CODE_W-1:0] mu_code;
  logic [CODE_W-1:0] a_code;

  for (genvar i = 0; i < CODE_W; i++) begin : g_rev
    assign rev_byte[i] = word[CODE_W-1-i];
  end

  frame_tx_mulaw u_mulaw (
    .lin  (word[WORD_W-1 -: MU_LIN_W]),
    .code (mu_code)
  );

  frame_tx_alaw u_alaw (
    .lin  (word[WORD_W-1 -: A_LIN_W]),
    .code (a_code)
  );

  always_comb begin
    unique case (tx_fmt_e'(fmt))
      FMT_MSB16: begin
        shift_word = word;
        shift_len  = LEN_W'(WORD_W);
      end
      FMT_LSB8: begin
        shift_word = {rev_byte, {PAD_W{1'b0}}};
        shift_len  = LEN_W'(CODE_W);
      end
      FMT_MULAW: begin
        shift_word = {mu_code, {PAD_W{1'b0}}};
        shift_len  = LEN_W'(CODE_W);
      end
      default: begin
        shift_word = {a_code, {PAD_W{1'b0}}};
        shift_len  = LEN_W'(CODE_W);
      end
    endcase
  end

endmodule

// File: rtl/frame_tx_hold.sv
module frame_tx_hold #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  input  logic              take,      // frame start
  output logic [WORD_W-1:0] word,      // word to send if take
  output logic              underrun
);
  logic              full_q;
  logic              ur_q;
  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] last_q;
  logic              load;

  assign in_ready = !full_q;
  assign load     = in_valid && !full_q;
  assign word     = full_q ? hold_q : last_q;
  assign underrun = ur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      ur_q   <= 1'b0;
      hold_q <= '0;
      last_q <= '0;
    end else begin
      if (take) begin
        if (full_q) begin
          last_q <= hold_q;
          full_q <= 1'b0;
        end else begin
          ur_q <= 1'b1;
        end
      end else if (load) begin
        ur_q <= 1'b0;
      end
      if (load) begin
        hold_q <= in_data;
        full_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/frame_tx_shifter.sv
module frame_tx_shifter
  import frame_tx_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int LEN_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic [1:0]        dly_sel,
  input  logic [WORD_W-1:0] fmt_word,
  input  logic [LEN_W-1:0]  fmt_len,
  output logic              start,
  output logic              busy,
  output logic [1:0]        state,
  output logic              sdout
);
  tx_st_e            st_q;
  logic [WORD_W-1:0] sh_q;
  logic [LEN_W-1:0]  left_q;
  logic [1:0]        dcnt_q;
  logic [1:0]        dly_eff;

  assign dly_eff = (dly_sel == 2'b11) ? 2'b00 : dly_sel;
  assign start   = (st_q == ST_IDLE) && fsync;
  assign busy    = (st_q != ST_IDLE);
  assign state   = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      left_q <= '0;
      dcnt_q <= '0;
      sdout  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          sdout <= 1'b0;
          if (fsync) begin
            if (dly_eff == 2'b00) begin
              sdout  <= fmt_word[WORD_W-1];
              sh_q   <= fmt_word << 1;
              left_q <= fmt_len - LEN_W'(1);
              st_q   <= ST_SHIFT;
            end else begin
              sh_q   <= fmt_word;
              left_q <= fmt_len;
              dcnt_q <= dly_eff - 2'd1;
              st_q   <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (dcnt_q == 2'd0) begin
            sdout  <= sh_q[WORD_W-1];
            sh_q   <= sh_q << 1;
            left_q <= left_q - LEN_W'(1);
            st_q   <= ST_SHIFT;
          end else begin
            dcnt_q <= dcnt_q - 2'd1;
          end
        end
        ST_SHIFT: begin
          if (left_q == '0) begin
            sdout <= 1'b0;
            st_q  <= ST_IDLE;
          end else begin
            sdout  <= sh_q[WORD_W-1];
            sh_q   <= sh_q << 1;
            left_q <= left_q - LEN_W'(1);
          end
        end
        default: begin
          sdout <= 1'b0;
          st_q  <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/frame_serial_tx.sv
module frame_serial_tx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic [1:0]        fmt_sel,
  input  logic [1:0]        dly_sel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              sdout,
  output logic              underrun
);
  localparam int LEN_W = $clog2(WORD_W + 1);

  logic              frame_start;
  logic              tx_busy;
  logic [1:0]        tx_state;
  logic [WORD_W-1:0] cur_word;
  logic [WORD_W-1:0] fmt_word;
  logic [LEN_W-1:0]  fmt_len;

  frame_tx_hold #(.WORD_W(WORD_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .take     (frame_start),
    .word     (cur_word),
    .underrun (underrun)
  );

  frame_tx_fmt #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_fmt (
    .word       (cur_word),
    .fmt        (fmt_sel),
    .shift_word (fmt_word),
    .shift_len  (fmt_len)
  );

  frame_tx_shifter #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .fsync    (fsync),
    .dly_sel  (dly_sel),
    .fmt_word (fmt_word),
    .fmt_len  (fmt_len),
    .start    (frame_start),
    .busy     (tx_busy),
    .state    (tx_state),
    .sdout    (sdout)
  );

endmodule

// File: rtl/frame_serial_tx_chk.sv
module frame_serial_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] dly_sel,
  input logic       in_valid,
  input logic       in_ready,
  input logic       sdout,
  input logic       underrun,
  input logic       start,
  input logic       busy,
  input logic [1:0] st
);
  // R9: an accepted word fills the register
  assert_ready_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R9: frame start empties a full register
  assert_ready_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !in_ready) |=> in_ready);

  // R10: frame on empty register raises the flag
  assert_underrun_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && in_ready) |=> underrun);

  // R10: a plain load clears the flag
  assert_underrun_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !start) |=> !underrun);

  // R10: flag is sticky without a load
  assert_underrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !(in_valid && in_ready)) |=> underrun);

  // R2: one-bit delay keeps the line low for one cycle
  assert_delay_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && dly_sel == 2'b01) |=> (!sdout && busy && st == 2'b01));

  // R2: codes 00 and 11 go straight to shifting
  assert_delay_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (dly_sel == 2'b00 || dly_sel == 2'b11)) |=> (st == 2'b10));

  // R8: idle line is low
  assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |-> !sdout);

  // R1: a busy transmitter never starts a frame
  assert_busy_no_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> !start);

endmodule

bind frame_serial_tx frame_serial_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dly_sel  (dly_sel),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .sdout    (sdout),
  .underrun (underrun),
  .start    (frame_start),
  .busy     (tx_busy),
  .st       (tx_state)
);

// File: tb/frame_serial_tx_test.sv
module frame_serial_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int TRACE_N    = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsync = 1'b0;
  logic [1:0]  fmt_sel = 2'b00;
  logic [1:0]  dly_sel = 2'b01;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        sdout;
  logic        underrun;

  int chk_cnt = 0;
  int fail_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_serial_tx uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .fsync    (fsync),
    .fmt_sel  (fmt_sel),
    .dly_sel  (dly_sel),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .sdout    (sdout),
    .underrun (underrun)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    chk_cnt++;
    if (act !== exp) begin
      fail_cnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference companders, written from the requirement text
  function automatic logic [7:0] mu_ref(input logic [15:0] w);
    int v, mag, seg, mant;
    logic [7:0] c;
    v = int'($signed(w[15:2]));
    mag = (v < 0) ? -v : v;
    if (mag > 8158) mag = 8158;
    mag = mag + 33;
    seg = 0;
    for (int s = 1; s < 8; s++) if (mag >= (1 << (s + 5))) seg = s;
    mant = (mag >> (seg + 1)) & 15;
    c = 8'((seg << 4) | mant);
    return c ^ ((v < 0) ? 8'h7F : 8'hFF);
  endfunction

  function automatic logic [7:0] a_ref(input logic [15:0] w);
    int v, mag, seg, mant;
    logic [7:0] c;
    v = int'($signed(w[15:3]));
    mag = (v < 0) ? (-v - 1) : v;
    seg = 0;
    for (int s = 1; s < 8; s++) if (mag >= (1 << (s + 4))) seg = s;
    mant = (seg < 2) ? ((mag >> 1) & 15) : ((mag >> seg) & 15);
    c = 8'((seg << 4) | mant);
    return c ^ ((v < 0) ? 8'h55 : 8'hD5);
  endfunction

  task automatic load_word(input logic [15:0] d);
    @(negedge clk);
    check("R9", "ready before load", 32'(in_ready), 32'd1);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9", "ready after load", 32'(in_ready), 32'd0);
  endtask

  // Start a frame and compare the sdout trace against the expected one.
  task automatic run_frame(input logic [1:0] m, input logic [1:0] d,
                           input logic [15:0] exp_word, input int len,
                           input bit disturb, input bit with_load,
                           input logic [15:0] ld, input string req);
    logic [TRACE_N-1:0] got;
    logic [TRACE_N-1:0] exp;
    int deff;
    deff = (d == 2'b11) ? 0 : int'(d);
    for (int i = 0; i < TRACE_N; i++) begin
      if (i >= deff && i < deff + len) exp[TRACE_N-1-i] = exp_word[15-(i-deff)];
      else exp[TRACE_N-1-i] = 1'b0;
    end
    @(negedge clk);
    fmt_sel = m;
    dly_sel = d;
    fsync   = 1'b1;
    if (with_load) begin
      in_valid = 1'b1;
      in_data  = ld;
    end
    @(negedge clk);
    fsync    = 1'b0;
    in_valid = 1'b0;
    for (int i = 0; i < TRACE_N; i++) begin
      got[TRACE_N-1-i] = sdout;
      if (disturb && i == 3) begin
        fmt_sel = ~m;
        dly_sel = ~d;
        fsync   = 1'b1;
      end
      if (disturb && i == 4) fsync = 1'b0;
      @(negedge clk);
    end
    check(req, "sdout trace", 32'(got), 32'(exp));
  endtask

  task automatic t_reset;
    check("R11", "sdout at reset", 32'(sdout), 32'd0);
    check("R11", "in_ready at reset", 32'(in_ready), 32'd1);
    check("R11", "underrun at reset", 32'(underrun), 32'd0);
  endtask

  task automatic t_msb;
    load_word(16'hA5C3);
    run_frame(2'b00, 2'b01, 16'hA5C3, 16, 1'b0, 1'b0, 16'h0, "R3");
    check("R9", "ready after frame start", 32'(in_ready), 32'd1);
    check("R10", "no underrun on fresh word", 32'(underrun), 32'd0);
  endtask

  task automatic t_delay;
    load_word(16'h5A3C);
    run_frame(2'b00, 2'b00, 16'h5A3C, 16, 1'b0, 1'b0, 16'h0, "R2 delay0");
    load_word(16'hC00B);
    run_frame(2'b00, 2'b10, 16'hC00B, 16, 1'b0, 1'b0, 16'h0, "R2 delay2");
    load_word(16'h8001);
    run_frame(2'b00, 2'b11, 16'h8001, 16, 1'b0, 1'b0, 16'h0, "R2 delay11");
  endtask

  task automatic t_lsb;
    load_word(16'hFFB4);   // low byte B4 reversed is 2D
    run_frame(2'b01, 2'b01, 16'h2D00, 8, 1'b0, 1'b0, 16'h0, "R4");
    load_word(16'h0001);
    run_frame(2'b01, 2'b10, 16'h8000, 8, 1'b0, 1'b0, 16'h0, "R4 bit0");
  endtask

  task automatic t_mulaw;
    logic [15:0] vals [7] = '{16'h0000, 16'h7FFC, 16'h8000, 16'hFFFC,
                              16'h0190, 16'hF060, 16'h1234};
    check("R5", "mu ref of zero", 32'(mu_ref(16'h0000)), 32'h00FF);
    check("R5", "mu ref of max", 32'(mu_ref(16'h7FFC)), 32'h0080);
    foreach (vals[i]) begin
      load_word(vals[i]);
      run_frame(2'b10, 2'b01, {mu_ref(vals[i]), 8'h00}, 8, 1'b0, 1'b0, 16'h0, "R5");
    end
  endtask

  task automatic t_alaw;
    logic [15:0] vals [8] = '{16'h0000, 16'h7FF8, 16'h8000, 16'hFFF8,
                              16'h00A0, 16'h0140, 16'h1F40, 16'hF6A0};
    check("R6", "A ref of zero", 32'(a_ref(16'h0000)), 32'h00D5);
    check("R6", "A ref of min", 32'(a_ref(16'h8000)), 32'h002A);
    foreach (vals[i]) begin
      load_word(vals[i]);
      run_frame(2'b11, 2'b00, {a_ref(vals[i]), 8'h00}, 8, 1'b0, 1'b0, 16'h0, "R6");
    end
  endtask

  // mid-word control changes and a stray fsync (R1, R7)
  task automatic t_midword;
    load_word(16'h3C96);
    run_frame(2'b00, 2'b00, 16'h3C96, 16, 1'b1, 1'b0, 16'h0, "R7 R1");
    check("R1", "no extra frame took a word (underrun)", 32'(underrun), 32'd0);
    load_word(16'h7E18);
    run_frame(2'b10, 2'b10, {mu_ref(16'h7E18), 8'h00}, 8, 1'b1, 1'b0, 16'h0, "R7");
    check("R1", "stray fsync left ready", 32'(in_ready), 32'd1);
    check("R8", "line low after word", 32'(sdout), 32'd0);
  endtask

  task automatic t_underrun;
    load_word(16'h3C96);
    run_frame(2'b00, 2'b01, 16'h3C96, 16, 1'b0, 1'b0, 16'h0, "R3");
    // empty register: resend previous word
    run_frame(2'b00, 2'b01, 16'h3C96, 16, 1'b0, 1'b0, 16'h0, "R10 resend");
    check("R10", "flag set", 32'(underrun), 32'd1);
    // load on the same edge as an underrun frame start
    run_frame(2'b00, 2'b01, 16'h3C96, 16, 1'b0, 1'b1, 16'h0F0F, "R10 coincident");
    check("R10", "flag set wins", 32'(underrun), 32'd1);
    check("R10", "coincident word held", 32'(in_ready), 32'd0);
    run_frame(2'b00, 2'b01, 16'h0F0F, 16, 1'b0, 1'b0, 16'h0, "R10 held word");
    check("R10", "flag sticky", 32'(underrun), 32'd1);
    load_word(16'h1111);
    check("R10", "flag cleared by load", 32'(underrun), 32'd0);
    run_frame(2'b00, 2'b00, 16'h1111, 16, 1'b0, 1'b0, 16'h0, "R3");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fail_cnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", chk_cnt, fail_cnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_msb();
    t_delay();
    t_lsb();
    t_mulaw();
    t_alaw();
    t_midword();
    t_underrun();
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", chk_cnt, fail_cnt);
    $finish;
  end

endmodule